// File: doc/BRIEF.md
# Cross-Processor Interrupt Flag and Mailbox Controller

This block carries interrupt requests and short messages between a host processor and a coprocessor that share it. Each side has three byte-wide write targets: a control register that raises interrupts on the *other* side and posts a message nibble to it, an enable register for its own interrupt sources, and a clear register that drops its own pending flags. Each side reads its state back as one flag status byte. Timer ticks, DMA completions and conversion-DMA completions come in as single-cycle event pulses.

On the host side there are two sources: a request raised by the coprocessor and a conversion-DMA completion. They drive one host interrupt line. This line is a latched level. It is raised when a pending source is enabled. Disabling the source does not lower it. Only a clear write that leaves no host flag pending lowers it. On the coprocessor side there are four sources: host request, timer, DMA and NMI. The request output is a plain gated OR of the first three, and NMI has its own output.

All state updates on the rising clock edge after the write or event. Every output is either a register or depends only on registers, so a value can be read back in the cycle after the edge that caused it.

Top module: `irq_mbx_ctrl`

## Requirements
- R1: After reset, both flag bytes read 0x00 and host_irq, cop_irq and cop_nmi are low.
- R2: The host flag byte has these bits: 7 = coprocessor request flag, 6 = IRQ-vector switch, 5 = conversion-DMA flag, 4 = NMI-vector switch, 3:0 = message from the coprocessor. A coprocessor control write (sel 0) sets bit 7 if its data bit 7 is 1. It loads bits 6, 4 and 3:0 from the same data bits.
- R3: The coprocessor flag byte has these bits: 7 = host request, 6 = timer, 5 = DMA, 4 = NMI, 3:0 = message from the host. A host control write (sel 0) sets bit 7 from data bit 7 and bit 4 from data bit 4, and loads bits 3:0 from the data. A timer_tick pulse sets bit 6 and a dma_done pulse sets bit 5. A cdma_done pulse sets host bit 5.
- R4: If a host source's enable (sel 1, bit 7 or bit 5) is on when its flag is set, host_irq is high in the next cycle.
- R5: If a host enable write turns an enable bit from 0 to 1 while the matching flag is pending, host_irq goes high in the next cycle.
- R6: A host clear write (sel 2) with bit 7 or bit 5 clears the matching flag. host_irq goes low only after a clear write that leaves both host flags at 0. Turning off an enable does not lower host_irq.
- R7: A coprocessor clear write (sel 2) clears the request, timer, DMA and NMI flags for data bits 7, 6, 5 and 4 respectively.
- R8: Coprocessor enables are written with sel 1, data bits 7..4. cop_irq is high exactly when the request, timer or DMA flag is pending with its enable on. cop_nmi is the NMI flag ANDed with its enable.
- R9: If a set event and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R10: A write with sel 3 from either side changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host target: 0 control, 1 enable, 2 clear, 3 none |
| host_wdata | input | 8 | Host write data |
| cop_we | input | 1 | Coprocessor register write strobe |
| cop_sel | input | 2 | Coprocessor target: 0 control, 1 enable, 2 clear, 3 none |
| cop_wdata | input | 8 | Coprocessor write data |
| cdma_done | input | 1 | Conversion-DMA completion pulse (host source) |
| timer_tick | input | 1 | Timer event pulse (coprocessor source) |
| dma_done | input | 1 | DMA completion pulse (coprocessor source) |
| host_flags | output | 8 | Host flag status byte |
| cop_flags | output | 8 | Coprocessor flag status byte |
| host_irq | output | 1 | Latched host interrupt line |
| cop_irq | output | 1 | Coprocessor interrupt request |
| cop_nmi | output | 1 | Coprocessor NMI request |

## Verification
The bench tests the host line's hysteresis with four cases:
- Clearing one flag while the other is still pending must not drop the line. A design that releases on any clear would lose a waiting conversion-DMA interrupt.
- Disabling a source must not drop the line. A design that gates the line combinationally would fail here.
- Enabling a source whose flag is already pending must raise the line at once. A design that reacts only to new set events would leave that interrupt stuck.
- Set and clear hitting the same flag in one cycle must leave the flag set. A clear-priority flag would silently drop the event.

Sel 3 writes must leave every byte intact. A decoder that aliases sel 3 onto another target would disturb them.

// File: rtl/irq_mbx_pkg.sv
package irq_mbx_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_IE   = 2'd1,
      SEL_CLR  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int N_COP_SRC = 4;  // request, timer, dma, nmi
endpackage

// File: rtl/irq_mbx_flag.sv
module irq_mbx_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o,
   output logic d_o
);
   generate
      if (SET_WINS) begin : g_set_prio
         assign d_o = set_i | (q_o & ~clr_i);
      end else begin : g_clr_prio
         assign d_o = (set_i | q_o) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= d_o;
   end
endmodule

// File: rtl/irq_mbx_host.sv
module irq_mbx_host #(
   parameter int DATA_W   = 8,
   parameter int MSG_W    = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ie_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] ctrl_data,
   input  logic              cdma_evt,
   output logic [DATA_W-1:0] flags_o,
   output logic              irq_o
);
   localparam int B_REQ  = DATA_W - 1;
   localparam int B_IVS  = DATA_W - 2;
   localparam int B_CDMA = DATA_W - 3;
   localparam int B_NVS  = DATA_W - 4;

   logic fl_req, fl_cdma, nx_req, nx_cdma;
   logic en_req_q, en_cdma_q, en_req_d, en_cdma_d;
   logic rise_req, rise_cdma, set_req, line_set, line_rel;
   logic ivs_q, nvs_q, line_q;
   logic [MSG_W-1:0] msg_q;
   logic unused_bits;

   assign set_req = ctrl_we & ctrl_data[B_REQ];

   irq_mbx_flag #(.SET_WINS(SET_WINS)) u_req (
      .clk(clk), .rst_n(rst_n), .set_i(set_req),
      .clr_i(clr_we & wdata[B_REQ]), .q_o(fl_req), .d_o(nx_req));

   irq_mbx_flag #(.SET_WINS(SET_WINS)) u_cdma (
      .clk(clk), .rst_n(rst_n), .set_i(cdma_evt),
      .clr_i(clr_we & wdata[B_CDMA]), .q_o(fl_cdma), .d_o(nx_cdma));

   assign en_req_d  = ie_we ? wdata[B_REQ]  : en_req_q;
   assign en_cdma_d = ie_we ? wdata[B_CDMA] : en_cdma_q;
   assign rise_req  = en_req_d  & ~en_req_q;
   assign rise_cdma = en_cdma_d & ~en_cdma_q;

   // raise on a new enabled event, or on enabling an already pending flag
   assign line_set = (set_req & en_req_d) | (cdma_evt & en_cdma_d)
                   | (rise_req & fl_req) | (rise_cdma & fl_cdma);
   // release only when a clear leaves nothing pending
   assign line_rel = clr_we & ~nx_req & ~nx_cdma;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_req_q  <= 1'b0;
         en_cdma_q <= 1'b0;
         ivs_q     <= 1'b0;
         nvs_q     <= 1'b0;
         msg_q     <= '0;
         line_q    <= 1'b0;
      end else begin
         en_req_q  <= en_req_d;
         en_cdma_q <= en_cdma_d;
         if (ctrl_we) begin
            ivs_q <= ctrl_data[B_IVS];
            nvs_q <= ctrl_data[B_NVS];
            msg_q <= ctrl_data[MSG_W-1:0];
         end
         if (line_set)      line_q <= 1'b1;
         else if (line_rel) line_q <= 1'b0;
      end
   end

   assign flags_o     = {fl_req, ivs_q, fl_cdma, nvs_q, msg_q};
   assign irq_o       = line_q;
   assign unused_bits = ^{wdata, ctrl_data};
endmodule

// File: rtl/irq_mbx_cop.sv
module irq_mbx_cop
   import irq_mbx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MSG_W    = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ie_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] ctrl_data,
   input  logic              timer_evt,
   input  logic              dma_evt,
   output logic [DATA_W-1:0] flags_o,
   output logic              irq_o,
   output logic              nmi_o
);
   localparam int B_TOP = DATA_W - 1;
   localparam int B_NMI = DATA_W - 4;

   // index 3 request, 2 timer, 1 dma, 0 nmi
   logic [N_COP_SRC-1:0] fl, nx, set_v, clr_v, en_q;
   logic [MSG_W-1:0]     msg_q;
   logic                 unused_bits;

   assign set_v = {ctrl_we & ctrl_data[B_TOP], timer_evt, dma_evt,
                   ctrl_we & ctrl_data[B_NMI]};
   assign clr_v = {N_COP_SRC{clr_we}} & wdata[B_TOP -: N_COP_SRC];

   generate
      for (genvar k = 0; k < N_COP_SRC; k++) begin : g_src
         irq_mbx_flag #(.SET_WINS(SET_WINS)) u_fl (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[k]), .clr_i(clr_v[k]),
            .q_o(fl[k]), .d_o(nx[k]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         msg_q <= '0;
      end else begin
         if (ie_we)   en_q  <= wdata[B_TOP -: N_COP_SRC];
         if (ctrl_we) msg_q <= ctrl_data[MSG_W-1:0];
      end
   end

   assign flags_o     = {fl, msg_q};
   assign irq_o       = |(fl[N_COP_SRC-1:1] & en_q[N_COP_SRC-1:1]);
   assign nmi_o       = fl[0] & en_q[0];
   assign unused_bits = ^{nx, wdata, ctrl_data};
endmodule

// File: rtl/irq_mbx_ctrl.sv
module irq_mbx_ctrl
   import irq_mbx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MSG_W    = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              cop_we,
   input  logic [1:0]        cop_sel,
   input  logic [DATA_W-1:0] cop_wdata,
   input  logic              cdma_done,
   input  logic              timer_tick,
   input  logic              dma_done,
   output logic [DATA_W-1:0] host_flags,
   output logic [DATA_W-1:0] cop_flags,
   output logic              host_irq,
   output logic              cop_irq,
   output logic              cop_nmi
);
   generate
      if (DATA_W != MSG_W + 4) begin : g_bad_width
         $error("irq_mbx_ctrl: DATA_W must equal MSG_W + 4");
      end
      if (MSG_W < 1) begin : g_bad_msg
         $error("irq_mbx_ctrl: MSG_W must be at least 1");
      end
   endgenerate

   logic h_ctrl, h_ie, h_clr, c_ctrl, c_ie, c_clr;

   assign h_ctrl = host_we & (reg_sel_e'(host_sel) == SEL_CTRL);
   assign h_ie   = host_we & (reg_sel_e'(host_sel) == SEL_IE);
   assign h_clr  = host_we & (reg_sel_e'(host_sel) == SEL_CLR);
   assign c_ctrl = cop_we  & (reg_sel_e'(cop_sel)  == SEL_CTRL);
   assign c_ie   = cop_we  & (reg_sel_e'(cop_sel)  == SEL_IE);
   assign c_clr  = cop_we  & (reg_sel_e'(cop_sel)  == SEL_CLR);

   irq_mbx_host #(.DATA_W(DATA_W), .MSG_W(MSG_W), .SET_WINS(SET_WINS)) u_host (
      .clk(clk), .rst_n(rst_n),
      .ie_we(h_ie), .clr_we(h_clr), .wdata(host_wdata),
      .ctrl_we(c_ctrl), .ctrl_data(cop_wdata),
      .cdma_evt(cdma_done),
      .flags_o(host_flags), .irq_o(host_irq));

   irq_mbx_cop #(.DATA_W(DATA_W), .MSG_W(MSG_W), .SET_WINS(SET_WINS)) u_cop (
      .clk(clk), .rst_n(rst_n),
      .ie_we(c_ie), .clr_we(c_clr), .wdata(cop_wdata),
      .ctrl_we(h_ctrl), .ctrl_data(host_wdata),
      .timer_evt(timer_tick), .dma_evt(dma_done),
      .flags_o(cop_flags), .irq_o(cop_irq), .nmi_o(cop_nmi));
endmodule

// File: rtl/irq_mbx_chk.sv
module irq_mbx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [1:0]        host_sel,
   input logic [DATA_W-1:0] host_wdata,
   input logic              cop_we,
   input logic [1:0]        cop_sel,
   input logic [DATA_W-1:0] cop_wdata,
   input logic              cdma_done,
   input logic              timer_tick,
   input logic              dma_done,
   input logic [DATA_W-1:0] host_flags,
   input logic [DATA_W-1:0] cop_flags,
   input logic              host_irq,
   input logic              cop_irq,
   input logic              cop_nmi
);
   localparam int T = DATA_W - 1;

   logic h_clr, c_ctrl_req, unused_bits;
   assign h_clr      = host_we && host_sel == 2'd2;
   assign c_ctrl_req = cop_we && cop_sel == 2'd0 && cop_wdata[T];
   assign unused_bits = ^{host_wdata, cop_wdata};

   p_ctrl_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctrl_req |=> host_flags[T]);

   p_events_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_tick || dma_done || cdma_done) |=>
         ((!$past(timer_tick) || cop_flags[T-1]) &&
          (!$past(dma_done) || cop_flags[T-2]) &&
          (!$past(cdma_done) || host_flags[T-2])));

   p_enable_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_sel == 2'd1 && host_wdata[T] && host_flags[T]) |=> host_irq);

   p_line_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> (host_flags[T] || host_flags[T-2]));

   p_line_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_irq && !h_clr) |=> host_irq);

   p_cop_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cop_irq |-> (|cop_flags[T -: 3]));

   p_cop_nmi_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cop_nmi |-> cop_flags[T-3]);

   p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (h_clr && host_wdata[T] && c_ctrl_req) |=> host_flags[T]);
endmodule

bind irq_mbx_ctrl irq_mbx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_irq_mbx_ctrl.sv
`timescale 1ns/1ps
module sim_irq_mbx_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0, cop_we = 1'b0;
   logic [1:0] host_sel = 2'd0, cop_sel = 2'd0;
   logic [7:0] host_wdata = 8'h00, cop_wdata = 8'h00;
   logic       cdma_done = 1'b0, timer_tick = 1'b0, dma_done = 1'b0;
   logic [7:0] host_flags, cop_flags;
   logic       host_irq, cop_irq, cop_nmi;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference state
   logic       m_hreq, m_hcdma, m_ivs, m_nvs, m_hen_req, m_hen_cdma, m_line;
   logic [3:0] m_hmsg, m_cfl, m_cen, m_cmsg;

   always #2 clk = ~clk;

   irq_mbx_ctrl u0 (.*);

   task automatic model_reset();
      {m_hreq, m_hcdma, m_ivs, m_nvs, m_hen_req, m_hen_cdma, m_line} = '0;
      m_hmsg = '0; m_cfl = '0; m_cen = '0; m_cmsg = '0;
   endtask

   task automatic model_step();
      logic hc, hi, hk, cc, ci, ck, s_req, n_req, n_cdma, e_req, e_cdma, lset;
      hc = host_we && host_sel == 2'd0; hi = host_we && host_sel == 2'd1;
      hk = host_we && host_sel == 2'd2;
      cc = cop_we && cop_sel == 2'd0;   ci = cop_we && cop_sel == 2'd1;
      ck = cop_we && cop_sel == 2'd2;
      // host side
      s_req  = cc && cop_wdata[7];
      n_req  = s_req || (m_hreq && !(hk && host_wdata[7]));
      n_cdma = cdma_done || (m_hcdma && !(hk && host_wdata[5]));
      e_req  = hi ? host_wdata[7] : m_hen_req;
      e_cdma = hi ? host_wdata[5] : m_hen_cdma;
      lset = (s_req && e_req) || (cdma_done && e_cdma) ||
             (e_req && !m_hen_req && m_hreq) || (e_cdma && !m_hen_cdma && m_hcdma);
      if (lset) m_line = 1'b1;
      else if (hk && !n_req && !n_cdma) m_line = 1'b0;
      m_hreq = n_req; m_hcdma = n_cdma; m_hen_req = e_req; m_hen_cdma = e_cdma;
      if (cc) begin
         m_ivs = cop_wdata[6]; m_nvs = cop_wdata[4]; m_hmsg = cop_wdata[3:0];
      end
      // coprocessor side
      m_cfl = ({hc && host_wdata[7], timer_tick, dma_done, hc && host_wdata[4]})
            | (m_cfl & ~(ck ? cop_wdata[7:4] : 4'h0));
      if (ci) m_cen = cop_wdata[7:4];
      if (hc) m_cmsg = host_wdata[3:0];
   endtask

   task automatic chk(input string tag, input string name, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, name, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "host_flags", host_flags, {m_hreq, m_ivs, m_hcdma, m_nvs, m_hmsg});
      chk(tag, "cop_flags", cop_flags, {m_cfl, m_cmsg});
      chk(tag, "host_irq", {7'd0, host_irq}, {7'd0, m_line});
      chk(tag, "cop_irq", {7'd0, cop_irq}, {7'd0, |(m_cfl[3:1] & m_cen[3:1])});
      chk(tag, "cop_nmi", {7'd0, cop_nmi}, {7'd0, m_cfl[0] & m_cen[0]});
   endtask

   // called at a falling edge: drive, predict, cross the rising edge, check
   task automatic step(input logic hwe, input logic [1:0] hs, input logic [7:0] hd,
                       input logic cwe, input logic [1:0] cs, input logic [7:0] cd,
                       input logic cdm, input logic tmr, input logic dmd,
                       input string tag);
      host_we = hwe; host_sel = hs; host_wdata = hd;
      cop_we = cwe; cop_sel = cs; cop_wdata = cd;
      cdma_done = cdm; timer_tick = tmr; dma_done = dmd;
      model_step();
      @(posedge clk);
      @(negedge clk);
      host_we = 1'b0; cop_we = 1'b0; cdma_done = 1'b0; timer_tick = 1'b0; dma_done = 1'b0;
      compare(tag);
   endtask

   task automatic hwr(input logic [1:0] s, input logic [7:0] d, input string tag);
      step(1'b1, s, d, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic cwr(input logic [1:0] s, input logic [7:0] d, input string tag);
      step(1'b0, 2'd0, 8'h00, 1'b1, s, d, 1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 reset state");

      cwr(2'd0, 8'hDA, "R2 cop control write fills host byte");
      hwr(2'd1, 8'h80, "R5 enable with request pending");
      hwr(2'd1, 8'h00, "R6 disable keeps line");
      step(1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R3 cdma event sets host bit5");
      hwr(2'd2, 8'h80, "R6 partial clear keeps line");
      hwr(2'd2, 8'h20, "R6 full clear releases line");
      hwr(2'd1, 8'h20, "R4 enable conversion source");
      step(1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R4 enabled event raises line");
      hwr(2'd2, 8'h20, "R6 clear conversion flag");
      hwr(2'd0, 8'h95, "R3 host control write");
      step(1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, "R3 timer and dma events");
      cwr(2'd1, 8'h10, "R8 nmi enable only");
      cwr(2'd1, 8'h40, "R8 timer enable only");
      cwr(2'd2, 8'hF0, "R7 clear all coprocessor flags");
      step(1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 8'h40, 1'b0, 1'b1, 1'b0, "R9 timer set beats clear");
      step(1'b1, 2'd2, 8'h80, 1'b1, 2'd0, 8'h80, 1'b0, 1'b0, 1'b0, "R9 request set beats clear");
      step(1'b1, 2'd3, 8'hFF, 1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, 1'b0, "R10 sel 3 ignored");

      for (int i = 0; i < 3000; i++) begin
         logic hwe, cwe;
         logic [1:0] hs, cs;
         hwe = ($urandom % 3) == 0; cwe = ($urandom % 3) == 0;
         hs = 2'($urandom); cs = 2'($urandom);
         step(hwe, hs, 8'($urandom), cwe, cs, 8'($urandom),
              ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
              "R2/R3/R6/R8 random");
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end
endmodule